// File: doc/BRIEF.md
# Interrupt line aggregation controller

This block gathers eleven device interrupt request lines into one processor interrupt. The interrupt is not a wire. It is a posted write: a data word goes to an address, and both come from one 32-bit target word that software programs. The block watches its inputs for changes, not for levels. A change on an enabled line is recorded as a request and starts one message write.

Software reads three views of the inputs. The request register reads and clears in one access. The pending register records changes on every line, masked or not, and also reads and clears. The level register shows the present state of each line. With these views, software can emulate level-triggered handling. After servicing, it checks the level view and rescans any line that is still asserted.

The lines are assigned as follows:
- bits 0 to 5: the six shared bus interrupts;
- bit 6: the external bus interrupt;
- bit 7: the default source;
- bit 10: the serial port;
- bit 8: no source.

Bit 9 is not implemented, so the implemented set is 0x5FF.

Each line passes through a two-flop synchroniser before change detection. The register bus is a simple single-cycle strobe bus. Read data is registered.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset the mask, request and pending registers read 0 and `msg_valid` is low.
- R2: Bit 9 is unimplemented. It reads 0 in the mask, request, pending and level registers, and a change on line 9 never produces a message. Writing 0x7FF to the mask reads back 0x5FF.
- R3: A rising or falling change on an enabled line (mask bit = 1) sets that bit in the request register and raises `msg_valid`, with `msg_addr = {target[31:5], 5'b0}` and `msg_data = target[4:0]`, zero-extended. The message is visible three clock edges after the input changes: two synchroniser edges, then one capture edge.
- R4: A change on a masked line (mask bit = 0) sets no request bit and produces no message, but it sets the pending bit for that line.
- R5: Unmasking a line that is already asserted produces no request and no message by itself. A later change on that line does produce them.
- R6: A read of the request register returns the captured requests and clears them, so an immediate second read returns 0.
- R7: A read of the pending register returns the pending bits and clears them. It leaves the level register unchanged.
- R8: The level register returns the synchronised state of every implemented line, regardless of the mask.
- R9: `msg_valid`, `msg_addr` and `msg_data` hold until a cycle with `msg_ready` high. Changes on enabled lines while a message is outstanding only merge into the request register. They produce no second message after acceptance.
- R10: While control bit 0 (hold) is 1, no message is issued, but requests still accumulate. When hold returns to 0 with requests recorded since the last message, exactly one message is issued.
- R11: The register map is: target 0x004, request 0x00C, mask 0x018, pending 0x01C, control 0x024, level 0x028. The target and control registers read back what was written, with only bit 0 kept in control. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 11 | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects apply) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| msg_valid | output | 1 | Message write outstanding |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench builds the block with its default parameters: eleven lines, implemented mask 0x5FF and a five-bit data field. At that size every line can be swept one at a time, both enabled and masked, and on both its rising and falling change. The sweep therefore covers the unimplemented bit 9 as well as the message address and data split. On top of the sweep, directed sequences cover three cases: unmasking an already-asserted line, a change merged while a message waits on `msg_ready`, and release of the hold bit.

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
  parameter int NLINES = 11,
  parameter logic [NLINES-1:0] IMPL = 11'h5FF,
  parameter int AW = 12,
  parameter int DB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam logic [AW-1:0] A_TGT  = AW'('h004);
  localparam logic [AW-1:0] A_REQ  = AW'('h00C);
  localparam logic [AW-1:0] A_MASK = AW'('h018);
  localparam logic [AW-1:0] A_PEND = AW'('h01C);
  localparam logic [AW-1:0] A_CTRL = AW'('h024);
  localparam logic [AW-1:0] A_LVL  = AW'('h028);
  localparam int PAD = 32 - NLINES;

  logic [NLINES-1:0] s1, lvl, lvl_d, mask_q, req_q, pend_q;
  logic [31:0] tgt_q;
  logic hold_q, trig_q;

  wire [NLINES-1:0] evt    = (lvl ^ lvl_d) & IMPL;
  wire [NLINES-1:0] evt_en = evt & mask_q;
  wire evt_any  = |evt_en;
  wire rd_req   = reg_rd && reg_addr == A_REQ;
  wire rd_pend  = reg_rd && reg_addr == A_PEND;
  wire issue    = !msg_valid && !hold_q && (evt_any || trig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; lvl <= '0; lvl_d <= '0;
    end else begin
      s1 <= irq_in; lvl <= s1; lvl_d <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0; tgt_q <= '0; hold_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_TGT:  tgt_q  <= reg_wdata;
        A_MASK: mask_q <= reg_wdata[NLINES-1:0] & IMPL;
        A_CTRL: hold_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0; pend_q <= '0;
    end else begin
      req_q  <= (rd_req  ? '0 : req_q)  | evt_en;
      pend_q <= (rd_pend ? '0 : pend_q) | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      if (reg_rd)
        case (reg_addr)
          A_TGT:  reg_rdata <= tgt_q;
          A_REQ:  reg_rdata <= {{PAD{1'b0}}, req_q};
          A_MASK: reg_rdata <= {{PAD{1'b0}}, mask_q};
          A_PEND: reg_rdata <= {{PAD{1'b0}}, pend_q};
          A_CTRL: reg_rdata <= {31'b0, hold_q};
          A_LVL:  reg_rdata <= {{PAD{1'b0}}, lvl & IMPL};
          default: ;
        endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0; trig_q <= 1'b0;
      msg_addr <= '0; msg_data <= '0;
    end else begin
      trig_q <= (trig_q || (evt_any && !msg_valid)) && !issue;
      if (issue) begin
        msg_valid <= 1'b1;
        msg_addr  <= {tgt_q[31:DB], {DB{1'b0}}};
        msg_data  <= {{(32-DB){1'b0}}, tgt_q[DB-1:0]};
      end else if (msg_ready) msg_valid <= 1'b0;
    end
  end

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R2
  bit9_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr != A_TGT |=> reg_rdata[9] == 1'b0);

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q && !msg_valid |=> !msg_valid);

  // R6
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && !evt_any |=> req_q == '0);
endmodule

// File: tb/test_irq_msg_ctrl.sv
module test_irq_msg_ctrl;
  logic clk = 0, rst = 1;
  logic [10:0] irq_in = '0;
  logic reg_wr = 0, reg_rd = 0, msg_ready = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, msg_addr, msg_data;
  logic msg_valid;
  int errors = 0, checks = 0;
  logic [31:0] v;

  localparam logic [31:0] TGT = 32'hF000_1234;
  localparam logic [31:0] EXP_A = 32'hF000_1220;
  localparam logic [31:0] EXP_D = 32'h0000_0014;

  always #5 clk = ~clk;

  irq_msg_ctrl i_irq_msg_ctrl (.clk, .rst, .irq_in, .reg_wr, .reg_rd, .reg_addr,
    .reg_wdata, .reg_rdata, .msg_valid, .msg_ready, .msg_addr, .msg_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 valid", {31'b0, msg_valid}, 0);
    rd(12'h018, v); chk("R1 mask", v, 0);
    rd(12'h00C, v); chk("R1 req", v, 0);
    rd(12'h01C, v); chk("R1 pend", v, 0);
    // R11 map, R2 mask readback
    wr(12'h004, TGT); rd(12'h004, v); chk("R11 target", v, TGT);
    wr(12'h018, 32'h7FF); rd(12'h018, v); chk("R2 mask 0x5FF", v, 32'h5FF);
    rd(12'h100, v); chk("R11 unmapped", v, 0);
    wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, v); chk("R11 ctrl", v, 1);
    wr(12'h024, 0);
    // R3 sweep of enabled lines, both directions
    for (int i = 0; i < 11; i++) begin
      for (int dir = 1; dir >= 0; dir--) begin
        logic [31:0] exp;
        exp = (i == 9) ? 32'h0 : (32'h1 << i);
        @(negedge clk); irq_in[i] = dir[0];
        settle();
        chk($sformatf("R3 valid line %0d", i), {31'b0, msg_valid}, {31'b0, i != 9});
        if (i != 9) begin
          chk("R3 addr", msg_addr, EXP_A);
          chk("R3 data", msg_data, EXP_D);
          accept();
        end
        rd(12'h00C, v); chk($sformatf("R6 req line %0d", i), v, exp);
        rd(12'h00C, v); chk("R6 req cleared", v, 0);
        rd(12'h01C, v); chk("R7 pend", v, exp);
      end
    end
    // R4 sweep of masked lines
    wr(12'h018, 0);
    for (int i = 0; i < 11; i++) begin
      logic [31:0] exp;
      exp = (i == 9) ? 32'h0 : (32'h1 << i);
      @(negedge clk); irq_in[i] = 1;
      settle();
      chk($sformatf("R4 no msg line %0d", i), {31'b0, msg_valid}, 0);
      rd(12'h00C, v); chk("R4 req", v, 0);
      rd(12'h028, v); chk("R8 level", v, exp);
      rd(12'h01C, v); chk("R4 pend", v, exp);
      rd(12'h028, v); chk("R7 level kept", v, exp);
      @(negedge clk); irq_in[i] = 0;
      settle();
      rd(12'h01C, v); chk("R4 pend fall", v, exp);
    end
    // R5 unmask while asserted
    @(negedge clk); irq_in = 11'h009;
    settle(); rd(12'h01C, v); chk("R5 pend", v, 32'h009);
    wr(12'h018, 32'h009); settle();
    chk("R5 no msg", {31'b0, msg_valid}, 0);
    rd(12'h00C, v); chk("R5 no req", v, 0);
    rd(12'h028, v); chk("R8 level masked-in", v, 32'h009);
    @(negedge clk); irq_in[0] = 0; settle();
    chk("R5 later change", {31'b0, msg_valid}, 1);
    accept();
    rd(12'h00C, v); chk("R5 req", v, 32'h001);
    @(negedge clk); irq_in = '0; settle();
    accept(); rd(12'h00C, v); rd(12'h01C, v);
    // R9 merge while outstanding
    wr(12'h018, 32'h7FF);
    @(negedge clk); irq_in[1] = 1; settle();
    chk("R9 valid", {31'b0, msg_valid}, 1);
    @(negedge clk); irq_in[2] = 1; settle();
    chk("R9 still valid", {31'b0, msg_valid}, 1);
    chk("R9 addr stable", msg_addr, EXP_A);
    accept(); settle();
    chk("R9 no second", {31'b0, msg_valid}, 0);
    rd(12'h00C, v); chk("R9 merged req", v, 32'h006);
    // R10 hold
    wr(12'h024, 1);
    @(negedge clk); irq_in[4] = 1; settle();
    chk("R10 held", {31'b0, msg_valid}, 0);
    wr(12'h024, 0); @(negedge clk);
    chk("R10 release", {31'b0, msg_valid}, 1);
    accept(); settle();
    chk("R10 single", {31'b0, msg_valid}, 0);
    rd(12'h00C, v); chk("R10 req", v, 32'h010);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule